// File: doc/BRIEF.md
# Key-Gated Register Write Protection

This block guards a small bank of memory-mapped 32-bit registers that sit behind a simple register bus. Each request carries a valid strobe, a write flag, a word address, write data and a flag that marks the access as coming from the debugger. One cycle after the request, the block answers with an acknowledge, an error flag and read data. A per-address mask parameter selects which data registers are protected.

A control word at byte offset 0x30 manages the protection. Bit 0 turns protection on and bit 1 locks the control word. A write to the control word counts only if its upper 24 bits carry the key value set by a parameter. While protection is on, ordinary writes to protected registers are dropped and answered with an error. While the lock is set, ordinary writes to the control word are dropped in the same way, and only a hardware reset releases the lock. Debugger writes pass both guards, but a debugger write to the control word still has to carry the key.

Top module: `wprot_unit`

## Requirements
- R1: After reset every response output is 0, the control word reads 0x00000000 and every data register reads 0.
- R2: A write to offset 0x30 whose bits 31:8 differ from the key (default 0x5A17C3) is answered with rsp_err=1 and leaves the control word unchanged.
- R3: Reading offset 0x30 returns bits 31:2 as zero, even after a write that put the key in bits 31:8 and ones in bits 7:2. Bit 0 reads as the enable and bit 1 as the lock.
- R4: A non-debugger write to offset 0x30 that carries the key, made while unlocked, loads the enable from bit 0 of the write data, whether that sets or clears it. The new setting governs the very next access.
- R5: While the enable is 1, a non-debugger write to a register whose PROT_MASK bit is set (default mask 0x00F0, so offsets 0x10 to 0x1C) is answered with rsp_err=1 and leaves the register unchanged. A write to an unmasked register is accepted without error.
- R6: While the enable is 0, writes to masked registers are accepted without error and can be read back.
- R7: While the lock is 1, a non-debugger write to offset 0x30 is answered with rsp_err=1 and changes nothing, even when it carries the key.
- R8: Once the lock is 1 it stays 1 through any bus write, debugger writes included, and returns to 0 only on reset.
- R9: A debugger write (req_dbg=1) to a masked register is accepted while the enable is 1. A debugger write to offset 0x30 that carries the key is accepted while the lock is 1. A debugger write to offset 0x30 with a wrong key is rejected with rsp_err=1.
- R10: Reads never return an error, whatever the protection state.
- R11: rsp_valid is a one-cycle pulse in the cycle after each request. rsp_err is only ever high together with rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dbg | input | 1 | Access originates from the debugger |
| req_addr | input | ADDR_W (6) | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Acknowledge, one cycle after the request |
| rsp_err | output | 1 | Error: the write was discarded |
| rsp_rdata | output | 32 | Read data; 0 for writes |

## Verification
The bench builds the block with its default parameters: 16 word slots, the control word in slot 12, key 0x5A17C3 and protect mask 0x00F0. This puts a protected register (0x10) and an unprotected one (0x08) next to the control word in the same small map. With that map, one short directed sequence can cover enabling, rejecting, debugger bypass, locking and the reset release. Many accesses are issued back to back, so the bench can see that a setting changed by one write governs the very next access.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int WORD_W = 32;
    localparam int KEY_W  = 24;
    localparam int KEY_LO = WORD_W - KEY_W;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_READ   = 2'd1,
        ACT_WRITE  = 2'd2,
        ACT_REJECT = 2'd3
    } wp_act_e;

    typedef struct packed {
        logic lock;
        logic en;
    } wp_ctrl_t;

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic [WORD_W-1:0] rsp_rdata;
        wp_ctrl_t          ctrl;
    } wp_state_t;

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode #(
    parameter int                     IDX_W     = 4,
    parameter int                     CTRL_IDX  = 12,
    parameter logic [(1<<IDX_W)-1:0]  PROT_MASK = '0,
    localparam int                    ADDR_W    = IDX_W + 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit_ctrl,
    output logic              hit_prot
);
    logic unused_byte_lane;

    always_comb begin
        idx              = addr[ADDR_W-1:2];
        hit_ctrl         = (idx == IDX_W'(CTRL_IDX));
        hit_prot         = PROT_MASK[idx] && !hit_ctrl;
        unused_byte_lane = ^addr[1:0];
    end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
(
    input  logic    req_valid,
    input  logic    req_write,
    input  logic    req_dbg,
    input  logic    hit_ctrl,
    input  logic    hit_prot,
    input  logic    key_ok,
    input  logic    ctrl_en,
    input  logic    ctrl_lock,
    output wp_act_e act
);
    always_comb begin
        if (!req_valid) begin
            act = ACT_IDLE;
        end else if (!req_write) begin
            act = ACT_READ;
        end else if (hit_ctrl) begin
            act = (key_ok && (!ctrl_lock || req_dbg)) ? ACT_WRITE : ACT_REJECT;
        end else begin
            act = (hit_prot && ctrl_en && !req_dbg) ? ACT_REJECT : ACT_WRITE;
        end
    end
endmodule

// File: rtl/wprot_bank.sv
module wprot_bank
    import wprot_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int CTRL_IDX = 12,
    localparam int SLOTS   = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [SLOTS*WORD_W-1:0] flat;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == CTRL_IDX) begin : g_hole
            assign flat[g*WORD_W +: WORD_W] = '0;
        end else begin : g_store
            logic [WORD_W-1:0] word_d;
            logic [WORD_W-1:0] word_q;

            always_comb begin
                word_d = word_q;
                if (we && (widx == IDX_W'(g))) begin
                    word_d = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end

            assign flat[g*WORD_W +: WORD_W] = word_q;
        end
    end

    assign rdata = flat[ridx*WORD_W +: WORD_W];
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int                     IDX_W     = 4,
    parameter int                     CTRL_IDX  = 12,
    parameter logic [KEY_W-1:0]       KEY       = 24'h5A17C3,
    parameter logic [(1<<IDX_W)-1:0]  PROT_MASK = 16'h00F0,
    localparam int                    ADDR_W    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dbg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    wp_state_t         st_d;
    wp_state_t         st_q;
    logic [IDX_W-1:0]  idx;
    logic              hit_ctrl;
    logic              hit_prot;
    logic              key_ok;
    logic              en_q;
    logic              lock_q;
    wp_act_e           act;
    logic              bank_we;
    logic [WORD_W-1:0] bank_rdata;

    assign en_q   = st_q.ctrl.en;
    assign lock_q = st_q.ctrl.lock;
    assign key_ok = (req_wdata[WORD_W-1:KEY_LO] == KEY);

    wprot_decode #(
        .IDX_W     (IDX_W),
        .CTRL_IDX  (CTRL_IDX),
        .PROT_MASK (PROT_MASK)
    ) u_decode (
        .addr     (req_addr),
        .idx      (idx),
        .hit_ctrl (hit_ctrl),
        .hit_prot (hit_prot)
    );

    wprot_gate u_gate (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_dbg   (req_dbg),
        .hit_ctrl  (hit_ctrl),
        .hit_prot  (hit_prot),
        .key_ok    (key_ok),
        .ctrl_en   (en_q),
        .ctrl_lock (lock_q),
        .act       (act)
    );

    assign bank_we = (act == ACT_WRITE) && !hit_ctrl;

    wprot_bank #(
        .IDX_W    (IDX_W),
        .CTRL_IDX (CTRL_IDX)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (idx),
        .wdata (req_wdata),
        .ridx  (idx),
        .rdata (bank_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = (act == ACT_REJECT);
        st_d.rsp_rdata = '0;
        if (act == ACT_READ) begin
            st_d.rsp_rdata = hit_ctrl ? {{(WORD_W-2){1'b0}}, lock_q, en_q} : bank_rdata;
        end
        if ((act == ACT_WRITE) && hit_ctrl) begin
            st_d.ctrl.en   = req_wdata[0];
            st_d.ctrl.lock = lock_q | req_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;
endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk #(
    parameter int                     IDX_W     = 4,
    parameter int                     CTRL_IDX  = 12,
    parameter logic [23:0]            KEY       = 24'h5A17C3,
    parameter logic [(1<<IDX_W)-1:0]  PROT_MASK = 16'h00F0,
    localparam int                    ADDR_W    = IDX_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_dbg,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              en_q,
    input logic              lock_q
);
    logic [IDX_W-1:0] a_idx;
    logic             a_ctrl;
    assign a_idx  = req_addr[ADDR_W-1:2];
    assign a_ctrl = (a_idx == IDX_W'(CTRL_IDX));

    assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_with_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    assert_read_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_err);

    assert_bad_key_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && a_ctrl && (req_wdata[31:8] != KEY)) |=> rsp_err);

    assert_err_keeps_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(en_q) && $stable(lock_q)));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_prot_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_dbg && en_q && !a_ctrl && PROT_MASK[a_idx]) |=> rsp_err);

    assert_locked_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_dbg && lock_q && a_ctrl) |=> rsp_err);

    assert_dbg_data_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_dbg && !a_ctrl) |=> !rsp_err);
endmodule

bind wprot_unit wprot_unit_chk #(
    .IDX_W     (IDX_W),
    .CTRL_IDX  (CTRL_IDX),
    .KEY       (KEY),
    .PROT_MASK (PROT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_dbg   (req_dbg),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .en_q      (en_q),
    .lock_q    (lock_q)
);

// File: tb/wprot_unit_test.sv
`timescale 1ns/1ps
module wprot_unit_test;
    localparam logic [23:0] KEY   = 24'h5A17C3;
    localparam logic [5:0]  A_CTL = 6'h30;
    localparam logic [5:0]  A_PRT = 6'h10;
    localparam logic [5:0]  A_OPN = 6'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dbg = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    wprot_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_dbg   (req_dbg),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one access at a falling edge; response is sampled one cycle later.
    task automatic access(input bit wr, input bit dbg, input logic [5:0] addr,
                          input logic [31:0] wd, output logic err, output logic [31:0] rd);
        req_valid = 1'b1;
        req_write = wr;
        req_dbg   = dbg;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R11 ack after request", 32'(rsp_valid), 32'd1);
        err = rsp_err;
        rd  = rsp_rdata;
    endtask

    task automatic t_reset();
        logic e; logic [31:0] d;
        do_reset();
        chk(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 idle response", {30'd0, rsp_valid, rsp_err}, 32'd0);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd0, "R1 control after reset", d, 32'd0);
        access(1'b0, 1'b0, A_PRT, '0, e, d);
        chk(d === 32'd0, "R1 data after reset", d, 32'd0);
    endtask

    task automatic t_bad_key();
        logic e; logic [31:0] d;
        access(1'b1, 1'b0, A_CTL, {24'h000001, 8'h01}, e, d);
        chk(e === 1'b1, "R2 wrong key error", 32'(e), 32'd1);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd0, "R2 control unchanged", d, 32'd0);
    endtask

    task automatic t_ctrl_fields();
        logic e; logic [31:0] d;
        access(1'b1, 1'b0, A_CTL, {KEY, 8'hFD}, e, d);
        chk(e === 1'b0, "R4 keyed write accepted", 32'(e), 32'd0);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd1, "R3 key and spare bits read zero", d, 32'd1);
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h00}, e, d);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd0, "R4 enable cleared", d, 32'd0);
        // enable then hit a protected register on the very next access
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h01}, e, d);
        access(1'b1, 1'b0, A_PRT, 32'hDEAD0001, e, d);
        chk(e === 1'b1, "R4 enable effective next access", 32'(e), 32'd1);
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h00}, e, d);
        access(1'b1, 1'b0, A_PRT, 32'hDEAD0002, e, d);
        chk(e === 1'b0, "R4 disable effective next access", 32'(e), 32'd0);
    endtask

    task automatic t_protect();
        logic e; logic [31:0] d;
        access(1'b1, 1'b0, A_PRT, 32'h0000AAAA, e, d);
        chk(e === 1'b0, "R6 write accepted while disabled", 32'(e), 32'd0);
        access(1'b0, 1'b0, A_PRT, '0, e, d);
        chk(d === 32'h0000AAAA, "R6 readback while disabled", d, 32'h0000AAAA);
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h01}, e, d);
        access(1'b1, 1'b0, A_PRT, 32'h00005555, e, d);
        chk(e === 1'b1, "R5 protected write rejected", 32'(e), 32'd1);
        access(1'b0, 1'b0, A_PRT, '0, e, d);
        chk(d === 32'h0000AAAA, "R5 protected register kept", d, 32'h0000AAAA);
        chk(e === 1'b0, "R10 read no error while enabled", 32'(e), 32'd0);
        access(1'b1, 1'b0, A_OPN, 32'h00001234, e, d);
        chk(e === 1'b0, "R5 unprotected write accepted", 32'(e), 32'd0);
        access(1'b0, 1'b0, A_OPN, '0, e, d);
        chk(d === 32'h00001234, "R5 unprotected readback", d, 32'h00001234);
    endtask

    task automatic t_debug();
        logic e; logic [31:0] d;
        access(1'b1, 1'b1, A_PRT, 32'h00007777, e, d);
        chk(e === 1'b0, "R9 debugger bypasses enable", 32'(e), 32'd0);
        access(1'b0, 1'b0, A_PRT, '0, e, d);
        chk(d === 32'h00007777, "R9 debugger write landed", d, 32'h00007777);
        access(1'b1, 1'b1, A_CTL, {24'h123456, 8'h00}, e, d);
        chk(e === 1'b1, "R9 debugger wrong key rejected", 32'(e), 32'd1);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd1, "R9 control kept after bad debugger key", d, 32'd1);
    endtask

    task automatic t_lock();
        logic e; logic [31:0] d;
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h03}, e, d);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd3, "R4 lock and enable set", d, 32'd3);
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h00}, e, d);
        chk(e === 1'b1, "R7 locked control rejected", 32'(e), 32'd1);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd3, "R7 control unchanged while locked", d, 32'd3);
        access(1'b1, 1'b1, A_CTL, {KEY, 8'h00}, e, d);
        chk(e === 1'b0, "R9 debugger keyed write while locked", 32'(e), 32'd0);
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd2, "R8 lock survives debugger clear", d, 32'd2);
        // R11: error pulse lasts one cycle only
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h01}, e, d);
        chk(e === 1'b1, "R7 locked rejection", 32'(e), 32'd1);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && rsp_err === 1'b0, "R11 single-cycle pulse",
            {30'd0, rsp_valid, rsp_err}, 32'd0);
        do_reset();
        access(1'b0, 1'b0, A_CTL, '0, e, d);
        chk(d === 32'd0, "R8 reset releases lock", d, 32'd0);
        access(1'b1, 1'b0, A_CTL, {KEY, 8'h01}, e, d);
        chk(e === 1'b0, "R8 control writable after reset", 32'(e), 32'd0);
    endtask

    initial begin
        t_reset();
        t_bad_key();
        t_ctrl_fields();
        t_protect();
        t_debug();
        t_lock();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule